// File: doc/BRIEF.md
# Single-Wire Serial Identity Responder

This block is a fully synchronous slave for a single open-drain, wired-AND data line. A bus master talks to it through time slots. The block holds a fixed 64-bit identity. It watches the synchronized level of the line and drives only a pull-down enable, which the pad turns into an open-drain output. A long low level on the line is taken as a bus reset. After a reset the block sends a presence pulse and then takes in an 8-bit command. It then either streams its identity, or joins a bit-by-bit elimination search among several slaves that share the line. Any other command makes it go quiet.

All timing is counted in clock cycles. The counts come from a single cycles-per-microsecond parameter, so one netlist serves any system clock that is a whole number of MHz. The identity has three parts: an 8-bit family code, a 48-bit serial number given as parameters, and a check byte. The check byte is computed while the design is elaborated.

Top module: `swid_responder`

## Requirements
- R1: The identity holds the family code (01h) in bits 7:0, the serial number in bits 55:8, and in bits 63:56 a CRC-8 of bits 55:0. The CRC uses the polynomial x^8+x^5+x^4+1, starts from zero and takes bit 0 first, so a CRC run over all 64 bits ends at zero.
- R2: A synchronized low level lasting at least 480 µs is a bus reset, detected when the line rises again. It aborts any transaction in progress and returns the block to command reception with an empty command register.
- R3: About 30 µs after a reset's rising edge (within 15–60 µs), the block pulls the line low for 120 µs as its presence pulse. The presence pulse never overlaps a data-slot pull-down.
- R4: A presence pulse follows only a valid reset. A low level shorter than 480 µs produces none.
- R5: A falling edge of the line opens a slot. In a write slot the line is sampled 30 µs after the edge, with high read as 1 and low as 0. The 8 command bits arrive least significant bit first.
- R6: After command 33h the block sends all 64 identity bits in 64 read slots, bit 0 first. It then goes quiet.
- R7: In a read slot a 0 is sent by holding the pull-down from just after the falling edge until 30 µs after it. A 1 is sent by never pulling.
- R8: After command F0h the block runs 64 triplets, bit 0 first. Each triplet is a read slot carrying the identity bit, a read slot carrying its complement, and a write slot carrying the master's chosen bit. After the 64th triplet the block goes quiet.
- R9: If the chosen bit in a triplet differs from the identity bit, the block drops out and stays quiet until the next reset.
- R10: Any command other than 33h and F0h (including 55h and CCh) leaves the line untouched until the next reset. A later reset restores normal operation.
- R11: After the reset input is released, the block stays quiet and ignores slots until it has seen its first bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLK_PER_US cycles per microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw logic level of the shared line (asynchronous) |
| pull_o | output | 1 | Pull-down enable for the open-drain driver |

## Verification
A wrong slot phase or bit index shows at the ports within one read slot, about 65 µs. The master sees a flipped bit in the streamed identity, or a true/complement pair that is not complementary. A command register that was not cleared, or a search that fails to drop out, shows as pull-downs during slots that should stay high. These begin in the first read slot after the faulty decision. Errors in presence timing show within 200 µs of the reset's rising edge, as the line level at fixed points on either side of the pulse.

// File: rtl/swid_pkg.sv
package swid_pkg;

    localparam logic [7:0] CMD_READ_ID = 8'h33;
    localparam logic [7:0] CMD_SEARCH  = 8'hF0;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CMD,
        ST_READ,
        ST_SRCH,
        ST_MUTE
    } ctrl_st_e;

    typedef enum logic [1:0] {
        PR_IDLE,
        PR_WAIT,
        PR_PULL
    } pres_st_e;

    // Reflected CRC-8, x^8+x^5+x^4+1, zero start, bit 0 first
    function automatic logic [7:0] crc8_lsb56(input logic [55:0] data);
        logic [7:0] c;
        logic       fb;
        c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            fb = c[0] ^ data[i];
            c  = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

endpackage

// File: rtl/swid_line_front.sv
module swid_line_front #(
    parameter int RST_CYC = 1920
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic fall_o,
    output logic rst_evt_o
);
    localparam int            CW      = $clog2(RST_CYC + 1);
    localparam logic [CW-1:0] LOW_MAX = CW'(RST_CYC);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          s3;
        logic [CW-1:0] low;
    } front_t;

    front_t fr_d, fr_q;

    always_comb begin
        fr_d    = fr_q;
        fr_d.s1 = line_i;
        fr_d.s2 = fr_q.s1;
        fr_d.s3 = fr_q.s2;
        if (fr_q.s2) begin
            fr_d.low = '0;
        end else if (fr_q.low != LOW_MAX) begin
            fr_d.low = fr_q.low + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= {1'b1, 1'b1, 1'b1, {CW{1'b0}}};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign lvl_o     = fr_q.s2;
    assign fall_o    = fr_q.s3 & ~fr_q.s2;
    assign rst_evt_o = ~fr_q.s3 & fr_q.s2 & (fr_q.low == LOW_MAX);

    AST_LOW_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.low <= LOW_MAX);                                   // R2
    AST_RESET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt_o |-> ($past(fr_q.low) == LOW_MAX || $past(fr_q.low) == LOW_MAX - 1'b1)); // R2

endmodule

// File: rtl/swid_presence.sv
module swid_presence
    import swid_pkg::*;
#(
    parameter int WAIT_CYC = 120,
    parameter int PULL_CYC = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic pull_o,
    output logic busy_o
);
    localparam int MAXC = (WAIT_CYC > PULL_CYC) ? WAIT_CYC : PULL_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_CYC - 1);
    localparam logic [CW-1:0] PULL_LAST = CW'(PULL_CYC - 1);

    typedef struct packed {
        pres_st_e      st;
        logic [CW-1:0] cnt;
    } pres_t;

    pres_t pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        if (start_i) begin
            pr_d.st  = PR_WAIT;
            pr_d.cnt = '0;
        end else begin
            case (pr_q.st)
                PR_WAIT: begin
                    if (pr_q.cnt == WAIT_LAST) begin
                        pr_d.st  = PR_PULL;
                        pr_d.cnt = '0;
                    end else begin
                        pr_d.cnt = pr_q.cnt + 1'b1;
                    end
                end
                PR_PULL: begin
                    if (pr_q.cnt == PULL_LAST) begin
                        pr_d.st  = PR_IDLE;
                        pr_d.cnt = '0;
                    end else begin
                        pr_d.cnt = pr_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_q <= {PR_IDLE, {CW{1'b0}}};
        end else begin
            pr_q <= pr_d;
        end
    end

    assign pull_o = (pr_q.st == PR_PULL);
    assign busy_o = (pr_q.st != PR_IDLE);

    AST_PRES_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pull_o) && !$past(start_i)) |-> ($past(pr_q.cnt) == PULL_LAST)); // R3

endmodule

// File: rtl/swid_ctrl.sv
module swid_ctrl
    import swid_pkg::*;
#(
    parameter logic [63:0] ID       = 64'h0,
    parameter int          SAMP_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic fall_i,
    input  logic rst_evt_i,
    input  logic gate_i,
    output logic pull_o
);
    localparam int            TW       = $clog2(SAMP_CYC + 1);
    localparam logic [TW-1:0] SAMP_PT  = TW'(SAMP_CYC);

    typedef struct packed {
        ctrl_st_e      st;
        logic          act;
        logic [TW-1:0] tcnt;
        logic [7:0]    cmd;
        logic [2:0]    ncmd;
        logic [5:0]    idx;
        logic [1:0]    ph;
    } ctrl_t;

    ctrl_t ct_d, ct_q;
    logic  tx_bit;
    logic  is_rd;
    logic  slot_ok;
    logic [7:0] cmd_full;

    always_comb begin
        tx_bit = 1'b1;
        is_rd  = 1'b0;
        case (ct_q.st)
            ST_READ: begin
                tx_bit = ID[ct_q.idx];
                is_rd  = 1'b1;
            end
            ST_SRCH: begin
                is_rd  = (ct_q.ph != 2'd2);
                tx_bit = (ct_q.ph == 2'd1) ? ~ID[ct_q.idx] : ID[ct_q.idx];
            end
            default: ;
        endcase
    end

    assign slot_ok  = (ct_q.st == ST_CMD) || (ct_q.st == ST_READ) || (ct_q.st == ST_SRCH);
    assign cmd_full = {lvl_i, ct_q.cmd[7:1]};

    always_comb begin
        ct_d = ct_q;
        if (rst_evt_i) begin
            ct_d.st   = ST_CMD;
            ct_d.act  = 1'b0;
            ct_d.tcnt = '0;
            ct_d.cmd  = '0;
            ct_d.ncmd = '0;
            ct_d.idx  = '0;
            ct_d.ph   = '0;
        end else if (!ct_q.act) begin
            if (fall_i && !gate_i && slot_ok) begin
                ct_d.act  = 1'b1;
                ct_d.tcnt = '0;
            end
        end else if (ct_q.tcnt != SAMP_PT) begin
            ct_d.tcnt = ct_q.tcnt + 1'b1;
        end else begin
            ct_d.act = 1'b0;
            case (ct_q.st)
                ST_CMD: begin
                    ct_d.cmd  = cmd_full;
                    ct_d.ncmd = ct_q.ncmd + 1'b1;
                    if (ct_q.ncmd == 3'd7) begin
                        ct_d.idx = '0;
                        ct_d.ph  = '0;
                        if (cmd_full == CMD_READ_ID)     ct_d.st = ST_READ;
                        else if (cmd_full == CMD_SEARCH) ct_d.st = ST_SRCH;
                        else                             ct_d.st = ST_MUTE;
                    end
                end
                ST_READ: begin
                    if (ct_q.idx == 6'd63) ct_d.st  = ST_MUTE;
                    else                   ct_d.idx = ct_q.idx + 1'b1;
                end
                ST_SRCH: begin
                    if (ct_q.ph != 2'd2) begin
                        ct_d.ph = ct_q.ph + 1'b1;
                    end else if (lvl_i != ID[ct_q.idx]) begin
                        ct_d.st = ST_MUTE;
                    end else if (ct_q.idx == 6'd63) begin
                        ct_d.st = ST_MUTE;
                    end else begin
                        ct_d.idx = ct_q.idx + 1'b1;
                        ct_d.ph  = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q <= {ST_OFF, 1'b0, {TW{1'b0}}, 8'h00, 3'd0, 6'd0, 2'd0};
        end else begin
            ct_q <= ct_d;
        end
    end

    assign pull_o = ct_q.act & is_rd & ~tx_bit;

    AST_RESET_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt_i |=> (ct_q.st == ST_CMD && !ct_q.act && ct_q.ncmd == 3'd0)); // R2
    AST_MUTE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.st == ST_MUTE && !rst_evt_i) |=> (ct_q.st == ST_MUTE));      // R10
    AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.st == ST_OFF && !rst_evt_i) |=> (ct_q.st == ST_OFF && !pull_o)); // R11
    AST_ZERO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_o && ct_q.tcnt != '0) |-> $past(pull_o));                   // R7

endmodule

// File: rtl/swid_responder.sv
module swid_responder
    import swid_pkg::*;
#(
    parameter int          CLK_PER_US = 4,
    parameter logic [7:0]  FAMILY     = 8'h01,
    parameter logic [47:0] SERIAL     = 48'h3A5C_9E12_07D4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic pull_o
);
    localparam int          RST_CYC  = 480 * CLK_PER_US;
    localparam int          PDH_CYC  = 30 * CLK_PER_US;
    localparam int          PDL_CYC  = 120 * CLK_PER_US;
    localparam int          SAMP_CYC = 30 * CLK_PER_US;
    localparam logic [7:0]  ID_CRC   = crc8_lsb56({SERIAL, FAMILY});
    localparam logic [63:0] ID_WORD  = {ID_CRC, SERIAL, FAMILY};

    logic lvl;
    logic fall;
    logic rst_evt;
    logic pres_pull;
    logic pres_busy;
    logic slot_pull;

    swid_line_front #(
        .RST_CYC (RST_CYC)
    ) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_i),
        .lvl_o     (lvl),
        .fall_o    (fall),
        .rst_evt_o (rst_evt)
    );

    swid_presence #(
        .WAIT_CYC (PDH_CYC),
        .PULL_CYC (PDL_CYC)
    ) u_pres (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rst_evt),
        .pull_o  (pres_pull),
        .busy_o  (pres_busy)
    );

    swid_ctrl #(
        .ID       (ID_WORD),
        .SAMP_CYC (SAMP_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl),
        .fall_i    (fall),
        .rst_evt_i (rst_evt),
        .gate_i    (pres_busy),
        .pull_o    (slot_pull)
    );

    assign pull_o = pres_pull | slot_pull;

    AST_PRES_NEEDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pres_busy) |-> $past(rst_evt));                     // R4
    AST_NO_DRIVE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pres_pull && slot_pull));                               // R3

endmodule

// File: tb/swid_responder_tb.sv
module swid_responder_tb_top;
    localparam int          CLK_PERIOD_NS = 10;
    localparam int          U   = 1;
    localparam logic [7:0]  FAM = 8'h01;
    localparam logic [47:0] SER = 48'h3A5C_9E12_07D4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_pull = 1'b0;
    logic pull_o;
    logic line;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] exp_id;

    assign line = ~(m_pull | pull_o);

    always #(CLK_PERIOD_NS / 2) clk = ~clk;

    swid_responder #(
        .CLK_PER_US (U),
        .FAMILY     (FAM),
        .SERIAL     (SER)
    ) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line),
        .pull_o (pull_o)
    );

    function automatic logic [7:0] tb_crc(input logic [63:0] v, input int n);
        logic [7:0] c;
        logic fb;
        c = 8'h00;
        for (int i = 0; i < n; i++) begin
            fb   = c[0] ^ v[i];
            c    = {fb, c[7:1]};
            c[3] = c[3] ^ fb;
            c[2] = c[2] ^ fb;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n * U) @(negedge clk);
    endtask

    task automatic bus_reset(output logic hi_early, output logic lo_mid, output logic hi_late);
        m_pull = 1'b1;
        wait_us(500);
        m_pull = 1'b0;
        wait_us(10);
        hi_early = line;
        wait_us(60);
        lo_mid = ~line;
        wait_us(130);
        hi_late = line;
        wait_us(60);
    endtask

    task automatic slot_write(input logic b, input int low1, input int low0);
        int lw;
        lw = b ? low1 : low0;
        m_pull = 1'b1;
        wait_us(lw);
        m_pull = 1'b0;
        wait_us(65 - lw);
    endtask

    task automatic slot_read(output logic b);
        m_pull = 1'b1;
        wait_us(4);
        m_pull = 1'b0;
        wait_us(11);
        b = line;
        wait_us(50);
    endtask

    task automatic send_byte(input logic [7:0] v, input int low1, input int low0);
        for (int i = 0; i < 8; i++) slot_write(v[i], low1, low0);
    endtask

    task automatic read_bits(input int n, output logic [63:0] v);
        logic b;
        v = '1;
        for (int i = 0; i < n; i++) begin
            slot_read(b);
            v[i] = b;
        end
    endtask

    task automatic quick_reset(input string tag);
        logic e, m, l;
        bus_reset(e, m, l);
        check(m === 1'b1, tag, {63'd0, m}, 64'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic e, m, l, b, c;
        int bad;
        exp_id = {tb_crc({8'h00, SER, FAM}, 56), SER, FAM};

        repeat (5) @(negedge clk);
        check(pull_o === 1'b0, "R11 reset state pull", {63'd0, pull_o}, 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R11: slots before any bus reset are ignored
        send_byte(8'h33, 6, 60);
        read_bits(8, v);
        check(v[7:0] == 8'hFF, "R11 quiet before first reset", v, 64'hFF);

        // R4: a short low gives no presence
        m_pull = 1'b1; wait_us(100); m_pull = 1'b0;
        wait_us(70);
        check(line === 1'b1, "R4 no presence after short low", {63'd0, line}, 64'd1);
        wait_us(150);

        // R3: presence timing
        bus_reset(e, m, l);
        check(e === 1'b1, "R3 line high 10us after reset", {63'd0, e}, 64'd1);
        check(m === 1'b1, "R3 presence low at 70us", {63'd0, m}, 64'd1);
        check(l === 1'b1, "R3 presence over by 200us", {63'd0, l}, 64'd1);

        // R4: short low after a valid reset still gives no presence
        m_pull = 1'b1; wait_us(300); m_pull = 1'b0;
        wait_us(70);
        check(line === 1'b1, "R4 no presence after 300us low", {63'd0, line}, 64'd1);
        wait_us(150);

        // R6 / R1: read identity
        quick_reset("R2 presence before read");
        send_byte(8'h33, 6, 60);
        read_bits(64, v);
        check(v == exp_id, "R6 identity stream", v, exp_id);
        check(v[7:0] == 8'h01, "R1 family code", {56'd0, v[7:0]}, 64'h01);
        check(tb_crc(v, 64) == 8'h00, "R1 crc residual", {56'd0, tb_crc(v, 64)}, 64'h0);
        read_bits(4, v);
        check(v[3:0] == 4'hF, "R6 quiet after 64 bits", {60'd0, v[3:0]}, 64'hF);

        // R5: write-slot sample point with stretched lows
        quick_reset("R5 presence");
        send_byte(8'h33, 25, 40);
        read_bits(64, v);
        check(v == exp_id, "R5 sample at 30us", v, exp_id);

        // R7: read-slot pull-down window
        quick_reset("R7 presence");
        send_byte(8'h33, 6, 60);
        m_pull = 1'b1; wait_us(4); m_pull = 1'b0; wait_us(16);
        check(pull_o === 1'b0, "R7 one bit not pulled", {63'd0, pull_o}, 64'd0);
        wait_us(45);
        m_pull = 1'b1; wait_us(4); m_pull = 1'b0; wait_us(16);
        check(pull_o === 1'b1, "R7 zero bit pulled at 20us", {63'd0, pull_o}, 64'd1);
        wait_us(25);
        check(pull_o === 1'b0, "R7 zero bit released by 45us", {63'd0, pull_o}, 64'd0);
        wait_us(20);

        // R8: full search following own identity
        quick_reset("R8 presence");
        send_byte(8'hF0, 6, 60);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            slot_read(b);
            slot_read(c);
            if (b !== exp_id[i] || c !== ~exp_id[i]) bad++;
            slot_write(exp_id[i], 6, 60);
        end
        check(bad == 0, "R8 triplet true/complement", bad, 0);
        read_bits(4, v);
        check(v[3:0] == 4'hF, "R8 quiet after last triplet", {60'd0, v[3:0]}, 64'hF);

        // R9: drop-out sweep over mismatch positions
        foreach (v[k]) begin
            if (k == 0 || k == 13 || k == 40 || k == 62 || k == 63) begin
                logic [63:0] w;
                quick_reset("R9 presence");
                send_byte(8'hF0, 6, 60);
                bad = 0;
                for (int i = 0; i <= k; i++) begin
                    slot_read(b);
                    slot_read(c);
                    if (b !== exp_id[i] || c !== ~exp_id[i]) bad++;
                    slot_write((i == k) ? ~exp_id[i] : exp_id[i], 6, 60);
                end
                check(bad == 0, "R9 pairs before mismatch", bad, 0);
                read_bits(6, w);
                check(w[5:0] == 6'h3F, "R9 silent after mismatch", {58'd0, w[5:0]}, 64'h3F);
            end
        end

        // R10: unsupported commands stay silent
        begin
            logic [7:0] cmds [4];
            cmds[0] = 8'h55; cmds[1] = 8'hCC; cmds[2] = 8'h00; cmds[3] = 8'hFF;
            for (int j = 0; j < 4; j++) begin
                quick_reset("R10 presence");
                send_byte(cmds[j], 6, 60);
                read_bits(16, v);
                check(v[15:0] == 16'hFFFF, "R10 silent on other command", {48'd0, v[15:0]}, 64'hFFFF);
            end
            quick_reset("R10 recovery presence");
            send_byte(8'h33, 6, 60);
            read_bits(64, v);
            check(v == exp_id, "R10 recovery after reset", v, exp_id);
        end

        // R2: reset aborts a read in progress
        quick_reset("R2 presence");
        send_byte(8'h33, 6, 60);
        read_bits(10, v);
        bus_reset(e, m, l);
        check(m === 1'b1, "R2 presence on abort reset", {63'd0, m}, 64'd1);
        send_byte(8'h33, 6, 60);
        read_bits(64, v);
        check(v == exp_id, "R2 full stream after abort", v, exp_id);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule